// File: doc/BRIEF.md
# Write Auto-Precharge Bank Tracker

This block sits beside a multi-bank DDR memory controller and watches the decoded command stream on its way to the memory. For every bank it follows the life of a write that closes its own row: the data burst, the write-recovery wait, the start of the internal precharge and the precharge period. At the end of that sequence the bank is idle again. Each bank's moment of internal precharge is reported as a one-cycle pulse, and each bank's idle state as a level.

Every command is also judged against the auto-precharge writes in flight. A command that breaks the slot rules raises a registered one-cycle violation pulse, tagged with the offending bank. An illegal command never changes the tracked state.

Burst length, write recovery, precharge time and minimum active time are parameters counted in clock cycles. The write data is taken to occupy the BL/2 cycles after the write command. Write recovery then runs from the first rising edge after the last strobe edge.

Top module: `wap_tracker`

## Requirements
- R1: After reset every bank reads idle, no precharge-start pulse is raised and the violation output is low.
- R2: Command codes on `cmd_i` are NOP 0, ACTIVATE 1, READ 2, READ+AP 3, WRITE 4, WRITE+AP 5 and PRECHARGE 6; code 7 behaves as NOP. An ACTIVATE at cycle a to an idle bank clears its idle bit from cycle a+1. A PRECHARGE at cycle t to an open bank sets the idle bit again at cycle t+T_RP.
- R3: A WRITE+AP at cycle t to an open bank that was activated at cycle a raises that bank's bit of `pre_start_o` for exactly one cycle, at cycle t+BL/2+1+T_WR, provided that cycle is not before a+T_RAS.
- R4: The internal precharge never begins before a+T_RAS. When write recovery ends earlier, the pulse comes at cycle a+T_RAS exactly.
- R5: A second WRITE+AP to the same bank at cycle t+1 (the interrupt slot) is legal and moves the pulse to cycle t+1+BL/2+1+T_WR.
- R6: After a precharge-start pulse at cycle p, the bank is not idle during cycles p to p+T_RP-1 and is idle from cycle p+T_RP.
- R7: A WRITE or WRITE+AP to any other bank in the interrupt slot of a running auto-precharge write is illegal. In later slots it is legal.
- R8: From the cycle after a WRITE+AP until the bank is idle again, and likewise while a bank is precharging after an explicit PRECHARGE, every command to that bank is illegal except the R5 case. This covers READ, READ+AP, WRITE, ACTIVATE, PRECHARGE and a WRITE+AP in a later slot.
- R9: ACTIVATE, PRECHARGE and READ commands to other banks are never flagged by a running auto-precharge write. A command to a bank that is not in an auto-precharge or precharge phase is flagged only under R7. Commands other than those in R2, R3 and R5 leave the state unchanged.
- R10: An illegal command at cycle n raises `viol_o` in cycle n+1, with `viol_bank_o` equal to its bank. An illegal command has no effect on any bank's state or timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_i | input | 3 | Decoded command of this cycle (codes in R2) |
| cmd_bank_i | input | BANK_W | Bank addressed by the command |
| pre_start_o | output | NUM_BANKS | One-cycle pulse per bank when its internal precharge begins |
| bank_idle_o | output | NUM_BANKS | Bank is precharged and may be activated |
| viol_o | output | 1 | Previous cycle's command was illegal |
| viol_bank_o | output | BANK_W | Bank of the last illegal command |

## Verification
The hardest situation to reach is a write in its interrupt slot that coincides with another bank's sequence at a different phase. A second write, a write to a second bank, or an access to a bank still precharging must each land on one exact cycle. Directed sequences place such commands on the counted slot: a same-bank rewrite at slot one, a cross-bank write at slot one and then slot two, and an ACTIVATE during precharge. A long run of biased random commands follows. A behavioural model keyed on absolute cycle numbers is compared with the outputs on every clock.

// File: rtl/wap_pkg.sv
`timescale 1ns/1ps
package wap_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_WR  = 3'd4,
    CMD_WRA = 3'd5,
    CMD_PRE = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_WRAP,
    BK_PREC
  } bank_st_e;
endpackage

// File: rtl/wap_bank.sv
`timescale 1ns/1ps
module wap_bank #(
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  wap_pkg::cmd_e cmd_i,
  output logic          in_seq_o,
  output logic          first_slot_o,
  output logic          pre_start_o,
  output logic          idle_o
);
  import wap_pkg::*;

  localparam int REC  = BURST_LEN / 2 + T_WR;
  localparam int M1   = (REC > T_RP) ? REC : T_RP;
  localparam int MAXV = (M1 > T_RAS) ? M1 : T_RAS;
  localparam int CW   = $clog2(MAXV + 1);

  bank_st_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] ras_q, ras_n;
  logic          ras_ok;

  assign ras_ok       = (ras_q == '0);
  assign in_seq_o     = (st_q == BK_WRAP) || (st_q == BK_PREC);
  assign first_slot_o = (st_q == BK_WRAP) && (cnt_q == CW'(REC));
  assign pre_start_o  = (st_q == BK_WRAP) && (cnt_q == '0) && ras_ok;
  assign idle_o       = (st_q == BK_IDLE);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    ras_n = ras_ok ? ras_q : ras_q - 1'b1;
    unique case (st_q)
      BK_IDLE: begin
        if (hit_i && cmd_i == CMD_ACT) begin
          st_n  = BK_OPEN;
          ras_n = CW'(T_RAS - 1);
        end
      end
      BK_OPEN: begin
        if (hit_i && cmd_i == CMD_WRA) begin
          st_n  = BK_WRAP;
          cnt_n = CW'(REC);
        end else if (hit_i && cmd_i == CMD_PRE) begin
          st_n  = BK_PREC;
          cnt_n = CW'(T_RP - 1);
        end
      end
      BK_WRAP: begin
        if (hit_i && cmd_i == CMD_WRA) begin
          cnt_n = CW'(REC);
        end else if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end else if (ras_ok) begin
          st_n  = BK_PREC;
          cnt_n = CW'(T_RP - 1);
        end
      end
      BK_PREC: begin
        if (cnt_q <= CW'(1)) begin
          st_n  = BK_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
      ras_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      ras_q <= ras_n;
    end
  end
endmodule

// File: rtl/wap_legal.sv
`timescale 1ns/1ps
module wap_legal #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wap_pkg::cmd_e        cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [NUM_BANKS-1:0] in_seq_i,
  input  logic [NUM_BANKS-1:0] first_slot_i,
  output logic                 accept_o,
  output logic                 viol_o,
  output logic [BANK_W-1:0]    viol_bank_o
);
  import wap_pkg::*;

  logic              live, is_write, other_first, illegal;
  logic              viol_q;
  logic [BANK_W-1:0] vbank_q, vbank_n;
  logic              vbank_en;

  always_comb begin
    other_first = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (first_slot_i[i] && bank_i != BANK_W'(i)) other_first = 1'b1;
    end
  end

  assign live     = (cmd_i != CMD_NOP) && (cmd_i != CMD_RSV);
  assign is_write = (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
  assign illegal  = live &&
                    ((in_seq_i[bank_i] && !(cmd_i == CMD_WRA && first_slot_i[bank_i])) ||
                     (is_write && other_first));
  assign accept_o = live && !illegal;

  assign vbank_en = illegal;
  assign vbank_n  = bank_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      vbank_q <= '0;
    end else begin
      viol_q <= illegal;
      if (vbank_en) vbank_q <= vbank_n;
    end
  end

  assign viol_o      = viol_q;
  assign viol_bank_o = vbank_q;
endmodule

// File: rtl/wap_tracker.sv
`timescale 1ns/1ps
module wap_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  output logic [NUM_BANKS-1:0] pre_start_o,
  output logic [NUM_BANKS-1:0] bank_idle_o,
  output logic                 viol_o,
  output logic [BANK_W-1:0]    viol_bank_o
);
  import wap_pkg::*;

  cmd_e                 cmd;
  logic                 accept;
  logic [NUM_BANKS-1:0] in_seq;
  logic [NUM_BANKS-1:0] first_slot;

  assign cmd = cmd_e'(cmd_i);

  wap_legal #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_legal (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd),
    .bank_i       (cmd_bank_i),
    .in_seq_i     (in_seq),
    .first_slot_i (first_slot),
    .accept_o     (accept),
    .viol_o       (viol_o),
    .viol_bank_o  (viol_bank_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = accept && (cmd_bank_i == BANK_W'(b));

    wap_bank #(
      .BURST_LEN (BURST_LEN),
      .T_WR      (T_WR),
      .T_RP      (T_RP),
      .T_RAS     (T_RAS)
    ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit_i        (hit),
      .cmd_i        (cmd),
      .in_seq_o     (in_seq[b]),
      .first_slot_o (first_slot[b]),
      .pre_start_o  (pre_start_o[b]),
      .idle_o       (bank_idle_o[b])
    );
  end
endmodule

// File: rtl/wap_tracker_chk.sv
`timescale 1ns/1ps
module wap_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_i,
  input logic [BANK_W-1:0]    cmd_bank_i,
  input logic [NUM_BANKS-1:0] pre_start_o,
  input logic [NUM_BANKS-1:0] bank_idle_o,
  input logic                 viol_o,
  input logic [NUM_BANKS-1:0] first_slot
);
  // R10: a violation always traces back to a real command
  a_r10_viol_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ($past(cmd_i) != 3'd0 && $past(cmd_i) != 3'd7));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R6: precharge period keeps the bank busy right after the start pulse
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o[b] |=> !bank_idle_o[b]);

    // R3: precharge start is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o[b] |=> !pre_start_o[b]);

    // R8: activating a bank whose precharge is starting is flagged
    a_r8_act_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd1 && cmd_bank_i == BANK_W'(b) && pre_start_o[b]) |=> viol_o);

    // R7: a write to another bank in this bank's interrupt slot is flagged
    a_r7_cross_write: assert property (@(posedge clk) disable iff (!rst_n)
      (first_slot[b] && (cmd_i == 3'd4 || cmd_i == 3'd5) && cmd_bank_i != BANK_W'(b))
      |=> viol_o);
  end
endmodule

bind wap_tracker wap_tracker_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_i       (cmd_i),
  .cmd_bank_i  (cmd_bank_i),
  .pre_start_o (pre_start_o),
  .bank_idle_o (bank_idle_o),
  .viol_o      (viol_o),
  .first_slot  (first_slot)
);

// File: tb/wap_tracker_bench.sv
`timescale 1ns/1ps
module wap_tracker_bench;
  localparam int NB   = 4;
  localparam int BL   = 4;
  localparam int TWR  = 2;
  localparam int TRP  = 3;
  localparam int TRAS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd_i;
  logic [1:0]    cmd_bank_i;
  logic [NB-1:0] pre_start_o, bank_idle_o;
  logic          viol_o;
  logic [1:0]    viol_bank_o;

  always #4 clk = ~clk;

  wap_tracker #(
    .NUM_BANKS (NB), .BURST_LEN (BL), .T_WR (TWR), .T_RP (TRP), .T_RAS (TRAS)
  ) u_wap_tracker (
    .clk (clk), .rst_n (rst_n), .cmd_i (cmd_i), .cmd_bank_i (cmd_bank_i),
    .pre_start_o (pre_start_o), .bank_idle_o (bank_idle_o),
    .viol_o (viol_o), .viol_bank_o (viol_bank_o)
  );

  // behavioural model: 0 idle, 1 open, 2 write+AP running, 3 precharging
  int    m_st [NB];
  int    m_act[NB];
  int    m_wr [NB];
  int    m_pre[NB];
  int    cyc;
  bit    e_viol;
  int    e_vbank;
  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input int c, input int bk);
    bit [NB-1:0] e_pre, e_idle;
    bit ill;
    @(negedge clk);
    for (int b = 0; b < NB; b++)
      if (m_st[b] == 3 && cyc >= m_pre[b] + TRP) m_st[b] = 0;
    for (int b = 0; b < NB; b++) begin
      e_pre[b]  = (m_st[b] == 2) && (cyc >= m_wr[b] + BL/2 + 1 + TWR) && (cyc >= m_act[b] + TRAS);
      e_idle[b] = (m_st[b] == 0);
    end
    check("pre_start", int'(pre_start_o), int'(e_pre));
    check("bank_idle", int'(bank_idle_o), int'(e_idle));
    check("viol", int'(viol_o), int'(e_viol));
    if (e_viol) check("viol_bank", int'(viol_bank_o), e_vbank);
    cmd_i      = 3'(c);
    cmd_bank_i = 2'(bk);
    ill = 1'b0;
    if (c >= 1 && c <= 6) begin
      if (m_st[bk] == 2 || m_st[bk] == 3)
        ill = !(c == 5 && m_st[bk] == 2 && cyc == m_wr[bk] + 1);
      if (c == 4 || c == 5)
        for (int o = 0; o < NB; o++)
          if (o != bk && m_st[o] == 2 && cyc == m_wr[o] + 1) ill = 1'b1;
      if (!ill) begin
        if (c == 1 && m_st[bk] == 0) begin m_st[bk] = 1; m_act[bk] = cyc; end
        else if (c == 5 && (m_st[bk] == 1 || m_st[bk] == 2)) begin m_st[bk] = 2; m_wr[bk] = cyc; end
        else if (c == 6 && m_st[bk] == 1) begin m_st[bk] = 3; m_pre[bk] = cyc; end
      end
    end
    e_viol = ill;
    if (ill) e_vbank = bk;
    for (int b = 0; b < NB; b++)
      if (e_pre[b]) begin m_st[b] = 3; m_pre[b] = cyc; end
    cyc++;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_act[b] = 0; m_wr[b] = 0; m_pre[b] = 0; end
    cyc = 0; e_viol = 1'b0; e_vbank = 0;
    rst_n = 1'b0; cmd_i = 3'd0; cmd_bank_i = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1 reset state";
    idle_n(2);

    tag = "R2 activate/precharge";
    step(1, 0); idle_n(8); step(6, 0); idle_n(5);

    tag = "R3 R6 write+AP timing";
    step(1, 1); idle_n(8); step(5, 1); idle_n(12);

    tag = "R4 minimum active time";
    step(1, 2); step(5, 2); idle_n(14);

    tag = "R5 same-bank rewrite";
    step(1, 3); idle_n(8); step(5, 3); step(5, 3); idle_n(12);

    tag = "R7 cross-bank write slots";
    step(1, 0); step(1, 1); idle_n(8); step(5, 0); step(4, 1); step(5, 1); idle_n(14);

    tag = "R8 R10 same-bank access during sequence";
    step(1, 2); idle_n(8); step(5, 2); step(0, 0); step(2, 2); step(5, 2); step(6, 2);
    step(3, 2); step(1, 2); idle_n(3); step(1, 2); idle_n(4); step(1, 2); idle_n(2);

    tag = "R9 other banks during sequence";
    step(1, 0); step(1, 3); idle_n(8); step(5, 0); step(1, 1); step(6, 3); step(2, 1);
    step(7, 0); idle_n(14);

    tag = "R2 R3 R5 R7 R8 R9 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      step(0, $urandom_range(0, 3));
      else if (r < 6) step(1, $urandom_range(0, 3));
      else if (r < 8) step(5, $urandom_range(0, 3));
      else            step($urandom_range(2, 7), $urandom_range(0, 3));
    end
    idle_n(20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule